// File: doc/BRIEF.md
# Input Sync Mode Detector

This block watches an incoming horizontal and vertical sync pair and measures the scan timing a host needs to identify the input format. It counts reference-clock cycles between successive horizontal sync pulses to get the line period, and counts horizontal pulses between vertical pulses to get the vertical total. It also decides the active polarity of each sync signal and classifies each field as odd or even. Choosing a display mode from these numbers is left to host firmware.

The host sees a small byte-wide register window. It holds an interrupt enable register, a pending register, a status register and four measurement bytes. The `irq` output is raised for three events, each maskable: a lasting change of line period, the arrival of a vertical sync, and the start of an odd field. Both sync inputs and the active-video flag are taken to be synchronous to `clk`. Internally, all timing is measured on the leading edge of each sync pulse after its polarity has been normalized.

Top module: `sync_mode_detector`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: The line period at addresses 3 (low byte) and 4 (high byte) equals the number of `clk` cycles between the two most recent leading edges of horizontal sync.
- R3: The vertical total at addresses 5 (low byte) and 6 (high byte) equals the number of horizontal sync leading edges between the two most recent vertical sync leading edges.
- R4: Status (address 2) bit 0 is 1 when horizontal sync is active-low, and bit 1 is 1 when vertical sync is active-low. A sync is judged active-low when it spends more cycles high than low over one of its own periods.
- R5: Status bit 2 is 1 when the latest vertical sync leading edge fell less than half a line period after the last horizontal leading edge (odd field), and 0 otherwise.
- R6: Pending bit 0 (rate change) sets only when two consecutive line periods each differ from the held reference period by more than TOL (default 2) cycles. Alternating periods that stay within TOL never set it.
- R7: Pending (address 1) bit 1 sets at every vertical sync leading edge.
- R8: Pending bit 2 sets at a vertical sync leading edge that starts an odd field, as defined in R5.
- R9: Writing to address 1 clears every pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R10: `irq` is high exactly when some pending bit is set whose enable bit is set at address 0 (bits 0..2, same order as pending).
- R11: Status bit 3 shows `vid_active_in` one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| vid_active_in | input | 1 | High while input is inside active video |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to host |

## Verification
The assertions assume the sync inputs change only between clock edges and are already synchronous to `clk`. They also assume that a vertical sync leading edge never lands in the same cycle as a horizontal leading edge. The stimulus meets both conditions: its generator updates every input on the falling clock edge, and it places the vertical edge a nonzero number of cycles into a line. Random timings keep each sync pulse shorter than half of its period, so the polarity decision is always well defined.

// File: rtl/smd_pkg.sv
package smd_pkg;
    localparam int unsigned SRC_N = 3;
    localparam int unsigned SRC_RATE  = 0;
    localparam int unsigned SRC_VSYNC = 1;
    localparam int unsigned SRC_ODD   = 2;

    typedef enum logic [2:0] {
        A_ENABLE  = 3'd0,
        A_PEND    = 3'd1,
        A_STATUS  = 3'd2,
        A_LINE_LO = 3'd3,
        A_LINE_HI = 3'd4,
        A_VTOT_LO = 3'd5,
        A_VTOT_HI = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/smd_polarity.sv
module smd_polarity #(
    parameter int unsigned CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic norm_rise,
    output logic active_low
);
    typedef struct packed {
        logic             prev_raw;
        logic             prev_norm;
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] lo_cnt;
        logic             act_low;
    } pol_state_t;

    localparam logic [CNT_W-1:0] SAT = '1;

    pol_state_t st_q, st_d;
    logic norm;

    always_comb begin
        st_d = st_q;
        norm = raw ^ st_q.act_low;
        norm_rise = norm & ~st_q.prev_norm;
        st_d.prev_raw  = raw;
        st_d.prev_norm = norm;
        if (raw && !st_q.prev_raw) begin
            // one full period of the raw signal has passed: decide
            st_d.act_low = (st_q.hi_cnt > st_q.lo_cnt);
            st_d.hi_cnt  = CNT_W'(1);
            st_d.lo_cnt  = '0;
        end else if (raw) begin
            if (st_q.hi_cnt != SAT) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end else begin
            if (st_q.lo_cnt != SAT) st_d.lo_cnt = st_q.lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_low = st_q.act_low;
endmodule

// File: rtl/smd_line_meter.sv
module smd_line_meter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TOL   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_edge,
    output logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] period,
    output logic             rate_change
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] ref_per;
        logic             miss;
    } meter_state_t;

    localparam logic [CNT_W-1:0] SAT = '1;

    meter_state_t st_q, st_d;
    logic [CNT_W-1:0] meas, diff;

    always_comb begin
        st_d = st_q;
        rate_change = 1'b0;
        meas = (st_q.cnt == SAT) ? SAT : st_q.cnt + 1'b1;
        diff = (meas > st_q.ref_per) ? meas - st_q.ref_per : st_q.ref_per - meas;
        if (st_q.cnt != SAT) st_d.cnt = st_q.cnt + 1'b1;
        if (line_edge) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.period = meas;
                if (diff > CNT_W'(TOL)) begin
                    if (st_q.miss) begin
                        rate_change  = 1'b1;
                        st_d.ref_per = meas;
                        st_d.miss    = 1'b0;
                    end else begin
                        st_d.miss = 1'b1;
                    end
                end else begin
                    st_d.miss = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase  = st_q.cnt;
    assign period = st_q.period;
endmodule

// File: rtl/sync_mode_detector.sv
module sync_mode_detector #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned VPOL_W  = 24,
    parameter int unsigned TOL     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       vid_active_in,
    input  logic [2:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    import smd_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] lines;
        logic             seen_v;
        logic [CNT_W-1:0] vtot;
        logic             odd;
        logic             active;
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] pend;
    } top_state_t;

    top_state_t st_q, st_d;

    logic h_edge, v_edge, h_low, v_low, change;
    logic [CNT_W-1:0] phase, period_w;
    logic [SRC_N-1:0] set_vec, clr_vec;
    logic odd_now;
    logic [15:0] per16, vtot16;

    smd_polarity #(.CNT_W(CNT_W)) u_hpol (
        .clk(clk), .rst_n(rst_n), .raw(hsync_in),
        .norm_rise(h_edge), .active_low(h_low)
    );

    smd_polarity #(.CNT_W(VPOL_W)) u_vpol (
        .clk(clk), .rst_n(rst_n), .raw(vsync_in),
        .norm_rise(v_edge), .active_low(v_low)
    );

    smd_line_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
        .clk(clk), .rst_n(rst_n), .line_edge(h_edge),
        .phase(phase), .period(period_w), .rate_change(change)
    );

    always_comb begin
        st_d = st_q;
        st_d.active = vid_active_in;
        odd_now = (phase < (period_w >> 1));
        if (h_edge) st_d.lines = st_q.lines + 1'b1;
        if (v_edge) begin
            if (st_q.seen_v) st_d.vtot = st_q.lines + CNT_W'(h_edge);
            st_d.lines  = '0;
            st_d.seen_v = 1'b1;
            st_d.odd    = odd_now;
        end
        set_vec = '0;
        set_vec[SRC_RATE]  = change;
        set_vec[SRC_VSYNC] = v_edge;
        set_vec[SRC_ODD]   = v_edge & odd_now;
        clr_vec = '0;
        if (reg_we && reg_addr == A_PEND) clr_vec = reg_wdata[SRC_N-1:0];
        if (reg_we && reg_addr == A_ENABLE) st_d.en = reg_wdata[SRC_N-1:0];
        // a new event in the same cycle as its clear keeps the bit set
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign per16  = 16'(period_w);
    assign vtot16 = 16'(st_q.vtot);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE:  reg_rdata = 8'(st_q.en);
            A_PEND:    reg_rdata = 8'(st_q.pend);
            A_STATUS:  reg_rdata = {4'b0, st_q.active, st_q.odd, v_low, h_low};
            A_LINE_LO: reg_rdata = per16[7:0];
            A_LINE_HI: reg_rdata = per16[15:8];
            A_VTOT_LO: reg_rdata = vtot16[7:0];
            A_VTOT_HI: reg_rdata = vtot16[15:8];
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(st_q.pend & st_q.en);
endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [2:0]       pend,
    input logic             h_edge,
    input logic             v_edge,
    input logic [CNT_W-1:0] period
);
    // R2: the measured period only moves on a horizontal leading edge
    p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(h_edge) |-> $stable(period));

    // R6: a rate-change flag needs a line edge to have caused it
    p_rate_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(h_edge));

    // R7: every vertical leading edge leaves the vsync flag pending
    p_vsync_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        v_edge |=> pend[1]);

    // R8: an odd-field flag appears together with a vsync event
    p_odd_with_vsync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[2]) |-> ($past(v_edge) && pend[1]));

    // R9: a pending bit only drops after a write of 1 to it
    p_w1c_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[0]) |-> $past(reg_we && reg_addr == 3'd1 && reg_wdata[0]));
    p_w1c_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[1]) |-> $past(reg_we && reg_addr == 3'd1 && reg_wdata[1]));
    p_w1c_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[2]) |-> $past(reg_we && reg_addr == 3'd1 && reg_wdata[2]));
endmodule

bind sync_mode_detector smd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend(st_q.pend), .h_edge(h_edge),
    .v_edge(v_edge), .period(period_w)
);

// File: tb/sim_sync_mode_detector.sv
`timescale 1ns/1ps
module sim_sync_mode_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, vid_active_in = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0, errors = 0, cyc = 0;

    // generator settings
    int  hper = 40, hwid = 4, jit = 0, vlines = 8, vwid = 80, voff = 3;
    bit  hneg = 0, vneg = 0, gen_on = 0;
    int  h_c = 0, l_c = 0, pos = 0;

    sync_mode_detector u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .vid_active_in(vid_active_in), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (gen_on) begin
            int lp;
            bit hs, vs;
            lp = hper + ((l_c % 2 == 1) ? jit : 0);
            hs = (h_c < hwid);
            vs = (pos >= voff) && (pos < voff + vwid);
            hsync_in      <= hs ^ hneg;
            vsync_in      <= vs ^ vneg;
            vid_active_in <= !vs && (h_c >= hwid + 2);
            pos++;
            if (h_c + 1 >= lp) begin
                h_c = 0;
                if (l_c + 1 >= vlines) begin l_c = 0; pos = 0; end
                else l_c++;
            end else h_c++;
        end
    end

    task automatic final_report();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            final_report();
        end
    end

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_odd(input int off, input int per);
        return (off - 1) < (per / 2);
    endfunction

    function automatic int rd16_exp(input int v);
        return v & 16'hffff;
    endfunction

    task automatic rd16(input logic [2:0] lo, output int v);
        logic [7:0] a, b;
        rd(lo, a); rd(lo + 3'd1, b);
        v = {b, a};
    endtask

    task automatic measure_checks(input string tag);
        int v;
        logic [7:0] s;
        rd16(3'd3, v); chk({"R2 period ", tag}, v, rd16_exp(hper));
        rd16(3'd5, v); chk({"R3 vtotal ", tag}, v, vlines);
        rd(3'd2, s);
        chk({"R4 hpol ", tag}, s[0], hneg);
        chk({"R4 vpol ", tag}, s[1], vneg);
        chk({"R5 odd ", tag}, s[2], exp_odd(voff, hper));
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v); chk("R1 reset reg", v, 0);
        end
        chk("R1 reset irq", irq, 0);

        // R11 active flag, generator idle
        @(negedge clk); vid_active_in = 1'b1; wait_cyc(2);
        rd(3'd2, v); chk("R11 active high", v[3], 1);
        @(negedge clk); vid_active_in = 1'b0; wait_cyc(2);
        rd(3'd2, v); chk("R11 active low", v[3], 0);

        // directed baseline: odd field, positive syncs
        hper = 40; hwid = 4; vlines = 8; vwid = 80; voff = 3; jit = 0;
        gen_on = 1;
        wait_cyc(5 * vlines * hper);
        measure_checks("base");
        wr(3'd1, 8'h07);
        rd(3'd1, v); chk("R9 cleared", v, 0);
        wait_cyc(vlines * hper + 5);
        rd(3'd1, v);
        chk("R7 vsync pend", v[1], 1);
        chk("R8 odd pend", v[2], 1);
        chk("R6 no change steady", v[0], 0);
        chk("R10 irq masked", irq, 0);
        wr(3'd0, 8'h02);
        chk("R10 irq enabled", irq, 1);
        wr(3'd1, 8'h02);
        rd(3'd1, v); chk("R9 only bit1 cleared", v, 8'h04);
        chk("R10 irq after clear", irq, 0);
        wr(3'd0, 8'h00);

        // R6 jitter within tolerance
        jit = 2;
        wait_cyc(3 * vlines * hper);
        wr(3'd1, 8'h07);
        wait_cyc(3 * vlines * hper);
        rd(3'd1, v); chk("R6 jitter ignored", v[0], 0);
        jit = 0;
        wait_cyc(vlines * hper);

        // R6 real rate change
        wr(3'd1, 8'h07);
        hper = 60; vwid = 120;
        wait_cyc(5 * hper);
        rd(3'd1, v); chk("R6 rate change set", v[0], 1);
        wr(3'd0, 8'h01);
        chk("R10 irq rate", irq, 1);
        wr(3'd0, 8'h00);

        // directed even field
        voff = hper / 2 + 4;
        wait_cyc(4 * vlines * hper);
        measure_checks("even");
        wr(3'd1, 8'h07);
        wait_cyc(vlines * hper + 5);
        rd(3'd1, v);
        chk("R8 even no odd pend", v[2], 0);
        chk("R7 vsync pend even", v[1], 1);

        // random timings
        for (int i = 0; i < 6; i++) begin
            hper   = 30 + int'($urandom % 50);
            hwid   = 3 + int'($urandom % 4);
            vlines = 6 + int'($urandom % 7);
            vwid   = 2 * hper;
            voff   = ($urandom % 2 == 1) ? 3 : hper / 2 + 4;
            hneg   = 1'($urandom % 2);
            vneg   = 1'($urandom % 2);
            wait_cyc(5 * vlines * hper);
            measure_checks($sformatf("rnd%0d", i));
            wr(3'd1, 8'h07);
            wait_cyc(vlines * hper + 5);
            rd(3'd1, v);
            chk("R7 vsync pend rnd", v[1], 1);
            chk("R8 odd pend rnd", v[2], exp_odd(voff, hper));
        end

        final_report();
    end
endmodule